// File: doc/BRIEF.md
# Core module control register file

This block is the control and configuration register bank of a processor core module. It sits on a simple word-addressed bus: one write strobe, a word index, write data, and read data that follows the index in the same cycle. It holds the main and auxiliary oscillator settings, the SDRAM and init settings, a control register, and a pair of flag words (volatile and non-volatile). Each flag word has its own set address and clear address. The two oscillator words are protected by a 16-bit key register. A write to either one takes effect only while the stored key matches the unlock value.

Three outputs leave the block. The control register drives an LED output and a boot-overlay output, which keeps boot memory mapped at address zero until software sets the remap bit. Writing the reset bit of the control register produces a one-cycle reset-request pulse. A second page of the bus shows a read-only identification table describing the memory module, including a size code derived from a parameter. A small local interrupt block holds a software interrupt bit and separate IRQ and FIQ enable masks. It drives an IRQ line and a FIQ line. Clock measurement, voltage control and counter words are not built: they read as zero and ignore writes.

Top module: `cm_regbank`

## Requirements
- R1: After reset the main oscillator (word 2) reads 0x01000048, auxiliary oscillator (word 7) 0x0007FEFF, SDRAM (word 8) 0x00011122, init (word 9) 0x00000112, and control, key, flags and both enable masks read zero; boot_overlay is 1 and led_on, rst_req, irq_out, fiq_out are 0.
- R2: A write to the key register (word 5) stores only data bits 15:0; a read returns the key in bits 15:0, bit 16 set exactly when the key equals 0xA05F, and zero above.
- R3: Writes to words 2 and 7 change the stored oscillator value only while the key equals 0xA05F; otherwise they are ignored.
- R4: Writes to SDRAM (word 8) and init (word 9) store the full 32-bit data, which reads back unchanged.
- R5: The control register (word 3) stores only bit 0 (LED) and bit 2 (remap); all other bits, including bit 3, read as zero; led_on equals bit 0 and boot_overlay equals the inverse of bit 2.
- R6: A control write with data bit 3 set makes rst_req high for exactly the one cycle after the write; no stored register changes because of it, and a control write with bit 3 clear leaves rst_req low.
- R7: A write to word 12 ORs the data into the flags, a write to word 13 clears the flag bits set in the data; words 14 and 15 do the same for the non-volatile flags; words 12 and 14 read the values and words 13 and 15 read zero.
- R8: A write to word 18 ORs the data into the IRQ enable mask and word 19 clears the mask bits set in the data; words 26 and 27 do the same for the FIQ mask; words 18 and 26 read the masks.
- R9: A write to word 20 with data bit 0 set sets the software interrupt level and a write to word 21 with bit 0 set clears it; other data bits have no effect; words 17, 20 and 25 read the level in bit 0.
- R10: Word 16 reads level AND IRQ mask and word 24 reads level AND FIQ mask; irq_out is high exactly when word 16 would read nonzero, fiq_out likewise for word 24.
- R11: Words 64 to 127 (byte offsets 0x100 to 0x1FF) read one zero-extended byte of the identification table, at entry = word index minus 64; entries 0, 1 and 2 are 0x80, 0x08 and 0x04, entry 31 is 64, 32, 16, 4 or 2 for a memory size of at least 256, 128, 64, 32 MB or less, and entries 32 to 63 read zero; writes there are ignored.
- R12: Any other word index (such as 0, 1, 6, 32 to 35 and everything from 128 up) reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | IDX_W | Word index (byte offset divided by four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current word index, combinational |
| boot_overlay | output | 1 | High while boot memory is mapped at address zero |
| led_on | output | 1 | LED drive from control bit 0 |
| rst_req | output | 1 | One-cycle system reset request |
| irq_out | output | 1 | Local IRQ request |
| fiq_out | output | 1 | Local FIQ request |

## Verification
The properties take for granted that the word index and write data are stable across the sampling edge, and that two control writes with the reset bit set never arrive in back-to-back cycles, since the single-cycle pulse check relies on that spacing. The stimulus keeps to this: every write is followed by an idle cycle with the strobe low, and inputs change only on the falling edge. Reads are checked a short delay after the index changes, because read data is combinational from the index and the stored state.

// File: rtl/cm_regbank_pkg.sv
package cm_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int KEY_W    = 16;
    localparam int SEL_W    = 6;
    localparam int ID_ENT_W = 6;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // word indices inside the register page; the order is fixed by software
    localparam sel_t SEL_OSC      = 6'd2;
    localparam sel_t SEL_CTRL     = 6'd3;
    localparam sel_t SEL_KEY      = 6'd5;
    localparam sel_t SEL_AUX      = 6'd7;
    localparam sel_t SEL_SDRAM    = 6'd8;
    localparam sel_t SEL_INIT     = 6'd9;
    localparam sel_t SEL_FLG_SET  = 6'd12;
    localparam sel_t SEL_FLG_CLR  = 6'd13;
    localparam sel_t SEL_NV_SET   = 6'd14;
    localparam sel_t SEL_NV_CLR   = 6'd15;
    localparam sel_t SEL_IRQ_STAT = 6'd16;
    localparam sel_t SEL_IRQ_RAW  = 6'd17;
    localparam sel_t SEL_IRQ_EN   = 6'd18;
    localparam sel_t SEL_IRQ_DIS  = 6'd19;
    localparam sel_t SEL_SW_SET   = 6'd20;
    localparam sel_t SEL_SW_CLR   = 6'd21;
    localparam sel_t SEL_FIQ_STAT = 6'd24;
    localparam sel_t SEL_FIQ_RAW  = 6'd25;
    localparam sel_t SEL_FIQ_EN   = 6'd26;
    localparam sel_t SEL_FIQ_DIS  = 6'd27;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

    localparam int CTRL_LED_BIT   = 0;
    localparam int CTRL_REMAP_BIT = 2;
    localparam int CTRL_RST_BIT   = 3;

    localparam word_t OSC_RST   = 32'h0100_0048;
    localparam word_t AUX_RST   = 32'h0007_FEFF;
    localparam word_t SDRAM_RST = 32'h0001_1122;
    localparam word_t INIT_RST  = 32'h0000_0112;

    typedef struct packed {
        word_t            osc;
        word_t            aux;
        word_t            sdram;
        word_t            init;
        word_t            flags;
        word_t            nvflags;
        logic [KEY_W-1:0] key;
        logic             led;
        logic             remap;
        logic             rst_req;
    } core_st_t;

    localparam core_st_t CORE_RST = '{
        osc:     OSC_RST,
        aux:     AUX_RST,
        sdram:   SDRAM_RST,
        init:    INIT_RST,
        flags:   '0,
        nvflags: '0,
        key:     '0,
        led:     1'b0,
        remap:   1'b0,
        rst_req: 1'b0
    };

    typedef struct packed {
        logic  level;
        word_t irq_en;
        word_t fiq_en;
    } irq_st_t;

    // memory size in MB to identification size code
    function automatic logic [7:0] size_code(input int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

endpackage

// File: rtl/cm_id_rom.sv
module cm_id_rom
    import cm_regbank_pkg::*;
#(
    parameter int MEM_MB = 128
) (
    input  logic [ID_ENT_W-1:0] entry,
    output logic [7:0]          id_byte
);

    localparam logic [7:0] SIZE_BYTE = size_code(MEM_MB);

    always_comb begin
        case (int'(entry))
            0:  id_byte = 8'h80;
            1:  id_byte = 8'h08;
            2:  id_byte = 8'h04;
            3:  id_byte = 8'h0B;
            4:  id_byte = 8'h09;
            5:  id_byte = 8'h01;
            6:  id_byte = 8'h40;
            8:  id_byte = 8'h02;
            9:  id_byte = 8'hA0;
            10: id_byte = 8'hA0;
            13: id_byte = 8'h08;
            15: id_byte = 8'h01;
            16: id_byte = 8'h0E;
            17: id_byte = 8'h04;
            18: id_byte = 8'h1C;
            19: id_byte = 8'h01;
            20: id_byte = 8'h02;
            21: id_byte = 8'h20;
            22: id_byte = 8'hC0;
            27: id_byte = 8'h30;
            28: id_byte = 8'h28;
            29: id_byte = 8'h30;
            30: id_byte = 8'h28;
            31: id_byte = SIZE_BYTE;
            default: id_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/cm_irq_local.sv
module cm_irq_local
    import cm_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_stb,
    input  sel_t  sel,
    input  word_t wdata,
    output word_t rd_val,
    output logic  irq_out,
    output logic  fiq_out
);

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            case (sel)
                SEL_IRQ_EN:  st_d.irq_en = st_q.irq_en | wdata;
                SEL_IRQ_DIS: st_d.irq_en = st_q.irq_en & ~wdata;
                SEL_FIQ_EN:  st_d.fiq_en = st_q.fiq_en | wdata;
                SEL_FIQ_DIS: st_d.fiq_en = st_q.fiq_en & ~wdata;
                SEL_SW_SET:  if (wdata[0]) st_d.level = 1'b1;
                SEL_SW_CLR:  if (wdata[0]) st_d.level = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    word_t level_w;
    assign level_w = word_t'(st_q.level);

    always_comb begin
        case (sel)
            SEL_IRQ_STAT: rd_val = level_w & st_q.irq_en;
            SEL_FIQ_STAT: rd_val = level_w & st_q.fiq_en;
            SEL_IRQ_RAW,
            SEL_FIQ_RAW,
            SEL_SW_SET:   rd_val = level_w;
            SEL_IRQ_EN:   rd_val = st_q.irq_en;
            SEL_FIQ_EN:   rd_val = st_q.fiq_en;
            default:      rd_val = '0;
        endcase
    end

    assign irq_out = st_q.level & st_q.irq_en[0];
    assign fiq_out = st_q.level & st_q.fiq_en[0];

endmodule

// File: rtl/cm_regbank.sv
module cm_regbank
    import cm_regbank_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int MEM_MB = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             boot_overlay,
    output logic             led_on,
    output logic             rst_req,
    output logic             irq_out,
    output logic             fiq_out
);

    localparam int PAGE_W = IDX_W - SEL_W;
    localparam logic [PAGE_W-1:0] PAGE_REG = '0;
    localparam logic [PAGE_W-1:0] PAGE_ID  = PAGE_W'(1);

    core_st_t st_d, st_q;

    logic [PAGE_W-1:0] page;
    sel_t              sel;
    logic              reg_hit, id_hit, reg_wr, unlocked;
    word_t             irq_rd;
    logic [7:0]        id_byte;

    assign page     = addr[IDX_W-1:SEL_W];
    assign sel      = addr[SEL_W-1:0];
    assign reg_hit  = (page == PAGE_REG);
    assign id_hit   = (page == PAGE_ID);
    assign reg_wr   = wr_en && reg_hit;
    assign unlocked = (st_q.key == UNLOCK_KEY);

    cm_irq_local u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (reg_wr),
        .sel     (sel),
        .wdata   (wdata),
        .rd_val  (irq_rd),
        .irq_out (irq_out),
        .fiq_out (fiq_out)
    );

    cm_id_rom #(.MEM_MB(MEM_MB)) u_rom (
        .entry   (addr[ID_ENT_W-1:0]),
        .id_byte (id_byte)
    );

    // next state
    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (reg_wr) begin
            case (sel)
                SEL_OSC:     if (unlocked) st_d.osc = wdata;
                SEL_AUX:     if (unlocked) st_d.aux = wdata;
                SEL_KEY:     st_d.key = wdata[KEY_W-1:0];
                SEL_SDRAM:   st_d.sdram = wdata;
                SEL_INIT:    st_d.init = wdata;
                SEL_CTRL: begin
                    st_d.led     = wdata[CTRL_LED_BIT];
                    st_d.remap   = wdata[CTRL_REMAP_BIT];
                    st_d.rst_req = wdata[CTRL_RST_BIT];
                end
                SEL_FLG_SET: st_d.flags   = st_q.flags | wdata;
                SEL_FLG_CLR: st_d.flags   = st_q.flags & ~wdata;
                SEL_NV_SET:  st_d.nvflags = st_q.nvflags | wdata;
                SEL_NV_CLR:  st_d.nvflags = st_q.nvflags & ~wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_RST;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata = word_t'(id_byte);
        end else if (reg_hit) begin
            case (sel)
                SEL_OSC:     rdata = st_q.osc;
                SEL_AUX:     rdata = st_q.aux;
                SEL_SDRAM:   rdata = st_q.sdram;
                SEL_INIT:    rdata = st_q.init;
                SEL_KEY:     rdata = word_t'({unlocked, st_q.key});
                SEL_CTRL: begin
                    rdata[CTRL_LED_BIT]   = st_q.led;
                    rdata[CTRL_REMAP_BIT] = st_q.remap;
                end
                SEL_FLG_SET: rdata = st_q.flags;
                SEL_NV_SET:  rdata = st_q.nvflags;
                default:     rdata = irq_rd;
            endcase
        end
    end

    assign boot_overlay = ~st_q.remap;
    assign led_on       = st_q.led;
    assign rst_req      = st_q.rst_req;

    // taps for the bound checker
    word_t            osc_now, flags_now;
    logic [KEY_W-1:0] key_now;
    assign osc_now   = st_q.osc;
    assign flags_now = st_q.flags;
    assign key_now   = st_q.key;

endmodule

// File: rtl/cm_regbank_chk.sv
module cm_regbank_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             boot_overlay,
    input logic             led_on,
    input logic             rst_req,
    input logic             irq_out,
    input logic [31:0]      osc_val,
    input logic [15:0]      key_val,
    input logic [31:0]      flags_val
);

    localparam logic [IDX_W-1:0] W_OSC  = IDX_W'(2);
    localparam logic [IDX_W-1:0] W_CTRL = IDX_W'(3);
    localparam logic [IDX_W-1:0] W_KEY  = IDX_W'(5);
    localparam logic [IDX_W-1:0] W_FCLR = IDX_W'(13);
    localparam logic [IDX_W-1:0] W_ISTA = IDX_W'(16);

    assert_key_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == W_KEY) |-> (rdata[16] == (key_val == 16'hA05F) && rdata[31:17] == '0));

    assert_locked_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == W_OSC && key_val != 16'hA05F) |=> $stable(osc_val));

    assert_ctrl_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == W_CTRL) |-> (!rdata[3] && rdata[2] == !boot_overlay && rdata[0] == led_on));

    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wr_en && addr == W_CTRL && wdata[3]));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == W_FCLR) |=> ((flags_val & $past(wdata)) == '0));

    assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == W_ISTA) |-> ((rdata != '0) == irq_out));

endmodule

bind cm_regbank cm_regbank_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .boot_overlay (boot_overlay),
    .led_on       (led_on),
    .rst_req      (rst_req),
    .irq_out      (irq_out),
    .osc_val      (osc_now),
    .key_val      (key_now),
    .flags_val    (flags_now)
);

// File: tb/sim_cm_regbank.sv
`timescale 1ns/1ps
module sim_cm_regbank;

    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             boot_overlay, led_on, rst_req, irq_out, fiq_out;

    always #5 clk = ~clk;

    cm_regbank #(.IDX_W(IDX_W), .MEM_MB(128)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .boot_overlay(boot_overlay), .led_on(led_on),
        .rst_req(rst_req), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct packed {
        logic        wr;
        logic [11:0] boff;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 65;
    // byte offsets; for reads data is the expected value
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h008, 32'h0100_0048, 4'd1},   // R1
        '{1'b0, 12'h01C, 32'h0007_FEFF, 4'd1},
        '{1'b0, 12'h020, 32'h0001_1122, 4'd1},
        '{1'b0, 12'h024, 32'h0000_0112, 4'd1},
        '{1'b0, 12'h00C, 32'h0000_0000, 4'd1},
        '{1'b0, 12'h014, 32'h0000_0000, 4'd1},
        '{1'b1, 12'h008, 32'h1234_5678, 4'd3},   // R3 locked write
        '{1'b0, 12'h008, 32'h0100_0048, 4'd3},
        '{1'b1, 12'h014, 32'hFFFF_A05F, 4'd2},   // R2 key
        '{1'b0, 12'h014, 32'h0001_A05F, 4'd2},
        '{1'b1, 12'h008, 32'h1234_5678, 4'd3},
        '{1'b0, 12'h008, 32'h1234_5678, 4'd3},
        '{1'b1, 12'h01C, 32'h00AB_CDEF, 4'd3},
        '{1'b0, 12'h01C, 32'h00AB_CDEF, 4'd3},
        '{1'b1, 12'h014, 32'h0000_1234, 4'd2},
        '{1'b0, 12'h014, 32'h0000_1234, 4'd2},
        '{1'b1, 12'h01C, 32'h0000_0000, 4'd3},
        '{1'b0, 12'h01C, 32'h00AB_CDEF, 4'd3},
        '{1'b1, 12'h020, 32'hDEAD_BEEF, 4'd4},   // R4
        '{1'b0, 12'h020, 32'hDEAD_BEEF, 4'd4},
        '{1'b1, 12'h024, 32'h0000_55AA, 4'd4},
        '{1'b0, 12'h024, 32'h0000_55AA, 4'd4},
        '{1'b1, 12'h030, 32'h0000_F00F, 4'd7},   // R7 flags
        '{1'b1, 12'h030, 32'h0000_0F00, 4'd7},
        '{1'b0, 12'h030, 32'h0000_FF0F, 4'd7},
        '{1'b1, 12'h034, 32'h0000_000F, 4'd7},
        '{1'b0, 12'h030, 32'h0000_FF00, 4'd7},
        '{1'b0, 12'h034, 32'h0000_0000, 4'd7},
        '{1'b1, 12'h038, 32'h0000_00A5, 4'd7},
        '{1'b1, 12'h03C, 32'h0000_0005, 4'd7},
        '{1'b0, 12'h038, 32'h0000_00A0, 4'd7},
        '{1'b0, 12'h030, 32'h0000_FF00, 4'd7},
        '{1'b1, 12'h048, 32'h0000_0003, 4'd8},   // R8 masks
        '{1'b0, 12'h048, 32'h0000_0003, 4'd8},
        '{1'b1, 12'h04C, 32'h0000_0002, 4'd8},
        '{1'b0, 12'h048, 32'h0000_0001, 4'd8},
        '{1'b1, 12'h068, 32'h0000_0001, 4'd8},
        '{1'b0, 12'h068, 32'h0000_0001, 4'd8},
        '{1'b0, 12'h040, 32'h0000_0000, 4'd10},  // R10
        '{1'b1, 12'h050, 32'hFFFF_FFFE, 4'd9},   // R9 bit0 only
        '{1'b0, 12'h044, 32'h0000_0000, 4'd9},
        '{1'b1, 12'h050, 32'h0000_0001, 4'd9},
        '{1'b0, 12'h044, 32'h0000_0001, 4'd9},
        '{1'b0, 12'h050, 32'h0000_0001, 4'd9},
        '{1'b0, 12'h040, 32'h0000_0001, 4'd10},
        '{1'b0, 12'h060, 32'h0000_0001, 4'd10},
        '{1'b0, 12'h064, 32'h0000_0001, 4'd9},
        '{1'b1, 12'h054, 32'hFFFF_FFFE, 4'd9},
        '{1'b0, 12'h044, 32'h0000_0001, 4'd9},
        '{1'b1, 12'h054, 32'h0000_0001, 4'd9},
        '{1'b0, 12'h044, 32'h0000_0000, 4'd9},
        '{1'b0, 12'h040, 32'h0000_0000, 4'd10},
        '{1'b0, 12'h100, 32'h0000_0080, 4'd11},  // R11 identification
        '{1'b0, 12'h104, 32'h0000_0008, 4'd11},
        '{1'b0, 12'h108, 32'h0000_0004, 4'd11},
        '{1'b0, 12'h17C, 32'h0000_0020, 4'd11},
        '{1'b0, 12'h180, 32'h0000_0000, 4'd11},
        '{1'b1, 12'h100, 32'h0000_00FF, 4'd11},
        '{1'b0, 12'h100, 32'h0000_0080, 4'd11},
        '{1'b1, 12'h080, 32'hFFFF_FFFF, 4'd12},  // R12 unbuilt words
        '{1'b0, 12'h080, 32'h0000_0000, 4'd12},
        '{1'b0, 12'h000, 32'h0000_0000, 4'd12},
        '{1'b0, 12'h018, 32'h0000_0000, 4'd12},
        '{1'b1, 12'h004, 32'h0000_0005, 4'd12},
        '{1'b0, 12'h004, 32'h0000_0000, 4'd12}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] boff, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = IDX_W'(boff >> 2);
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] boff, input logic [31:0] exp);
        @(negedge clk);
        addr = IDX_W'(boff >> 2);
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 outputs after reset
        check("R1 boot_overlay", 32'(boot_overlay), 32'd1);
        check("R1 led_on", 32'(led_on), 32'd0);
        check("R1 rst_req", 32'(rst_req), 32'd0);
        check("R1 irq_out", 32'(irq_out), 32'd0);
        check("R1 fiq_out", 32'(fiq_out), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].boff, VEC[i].data);
            else rd($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].boff, VEC[i].data);
        end

        // R5 R6: control write with LED, remap and reset bits
        wr(12'h00C, 32'h0000_000D);
        #1;
        check("R6 pulse high", 32'(rst_req), 32'd1);
        check("R5 led_on set", 32'(led_on), 32'd1);
        check("R5 overlay removed", 32'(boot_overlay), 32'd0);
        addr = IDX_W'(3);
        #1;
        check("R5 control readback", rdata, 32'h0000_0005);
        addr = IDX_W'(2);
        #1;
        check("R6 oscillator untouched", rdata, 32'h1234_5678);
        @(negedge clk);
        #1;
        check("R6 pulse ends", 32'(rst_req), 32'd0);

        // R5 R6: other bits dropped, no pulse without bit 3
        wr(12'h00C, 32'hFFFF_FFF2);
        #1;
        check("R6 no pulse", 32'(rst_req), 32'd0);
        check("R5 overlay back", 32'(boot_overlay), 32'd1);
        check("R5 led off", 32'(led_on), 32'd0);
        rd("R5 control zero", 12'h00C, 32'h0);

        // R10 interrupt lines (both masks have bit 0 set here)
        wr(12'h050, 32'h1);
        #1;
        check("R10 irq_out on", 32'(irq_out), 32'd1);
        check("R10 fiq_out on", 32'(fiq_out), 32'd1);
        wr(12'h06C, 32'h1);
        #1;
        check("R10 fiq_out masked", 32'(fiq_out), 32'd0);
        check("R10 irq_out kept", 32'(irq_out), 32'd1);
        wr(12'h04C, 32'h1);
        #1;
        check("R10 irq_out masked", 32'(irq_out), 32'd0);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            report();
            $finish;
        end
    end

endmodule